// File: doc/BRIEF.md
# Prescaled Capture Timer

A 16-bit free-running timer whose tick rate comes from a power-of-two clock divider. Three capture channels each take a copy of the running count when their strobe is high at a clock edge. Each capture also raises a per-channel event flag. The count rolling over from its top value back to zero raises an overflow flag. A single interrupt line combines these flags, each gated by its enable.

Software reaches the block through a byte-wide register port with a separate read strobe and write strobe. A read of the count's upper byte freezes the lower byte in a holding register. A later read of the lower byte therefore pairs with it into one consistent 16-bit value.

The divide ratio can only be chosen during a short window after reset. After that it is fixed, and any further attempt to change it is ignored. Both flag registers clear only on a write of one.

Register map (4-bit address):

| Address | Content |
|---------|---------|
| 0 | count upper byte |
| 1 | held lower byte |
| 2, 3 | channel 1 capture, upper then lower byte |
| 4, 5 | channel 2 capture, upper then lower byte |
| 6, 7 | channel 3 capture, upper then lower byte |
| 8 | control |
| 9 | overflow flag |
| 10 | capture flags |

Top module: `tmr_capture_timer`

## Requirements
- R1: The 16-bit count starts at 0x0000 after reset. It advances by one on every divider tick, wraps from 0xFFFF to 0x0000, and holds between ticks.
- R2: Control bits 1:0 select the divide ratio: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16 clock cycles per tick.
- R3: The divide field takes a write only during the first LOCK_CYCLES (64) clock cycles after reset. Later writes to the control register leave bits 1:0 unchanged, while bits 7 and 6:4 still take the written value.
- R4: A capture strobe that is high at a clock edge copies the count held before that edge into the channel's register pair. The upper byte is at the lower address (channel 1 at 2/3, channel 2 at 4/5, channel 3 at 6/7).
- R5: Reading address 0 returns the count's upper byte and copies the lower byte into a holding register in the same edge. Address 1 returns the held byte.
- R6: Bit 7 of the overflow flag register (address 9) sets at the edge where the count rolls from 0xFFFF to 0x0000. The other bits of that register read zero.
- R7: A capture sets its channel's flag in the capture flag register (address 10): channel 1 at bit 2, channel 2 at bit 1 and channel 3 at bit 0.
- R8: A write to a flag register clears only the set flags written as one. Bits written as zero keep their state. A flag event in the same edge as its clear leaves the flag set.
- R9: irq is high exactly when some flag is set while its enable is set. The overflow enable is control bit 7. The capture enables are control bit 6 for channel 1, bit 5 for channel 2 and bit 4 for channel 3.
- R10: Reset clears the control register (divide by 1, all enables off), both flag registers and the count.
- R11: Read data appears on rdata one clock edge after the read strobe and holds until the next read. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| capStrobe | input | NUM_CAP (3) | Capture strobes, bit 0 is channel 1 |
| irq | output | 1 | Interrupt request |

## Verification
The timing rules below set when each check samples. A register write takes effect at the edge it is presented on. The next falling-edge sample sees its effect, and irq follows at that sample because it is decoded from registers without further delay. Read data is due one edge after the strobe: the scoreboard queues the expected byte when the read is issued and pops it at the falling edge after that edge. The divider ratio is checked by capturing on two channels exactly 64 edges apart, a multiple of every ratio, so the captured difference is 64 divided by the ratio whatever the divider phase. The wrap is pinned by capturing on the edge right after irq is first seen, which must return 0x0000.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam int DIV_W  = 4;

  localparam logic [ADDR_W-1:0] ADR_CNT_HI   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_CNT_LO   = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_CAP_BASE = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_CTRL     = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_OVF      = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_CAPF     = 4'd10;

  // Bit positions inside the control and flag bytes
  localparam int OVF_BIT     = 7;
  localparam int CAPEN_TOP   = 6;
  localparam int CAPFLAG_TOP = 2;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic [1:0] divSel;
    logic       snapHi;
  } tmr_ctrl_t;

  function automatic logic [DIV_W-1:0] divMask(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'h0;
      2'b01:   return 4'h3;
      2'b10:   return 4'h7;
      default: return 4'hF;
    endcase
  endfunction
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int NUM_CAP = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  tmr_ctrl_t                       ctl,
  input  logic [NUM_CAP-1:0]              capStrobe,
  output logic [CNT_W-1:0]                count,
  output logic [NUM_CAP-1:0][CNT_W-1:0]   capVal,
  output logic [BYTE_W-1:0]               holdLo,
  output logic                            tick,
  output logic                            wrapEvt
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divM;

  // Free-running divider; a tick fires when the selected low bits are all ones
  always_ff @(posedge clk) begin
    if (rst) divCnt <= '0;
    else     divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    divM    = divMask(ctl.divSel);
    tick    = ((divCnt & divM) == divM);
    wrapEvt = tick && (count == {CNT_W{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (tick) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             holdLo <= '0;
    else if (ctl.snapHi) holdLo <= count[BYTE_W-1:0];
  end

  for (genvar g = 0; g < NUM_CAP; g++) begin : gCap
    always_ff @(posedge clk) begin
      if (rst)               capVal[g] <= '0;
      else if (capStrobe[g]) capVal[g] <= count;
    end
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int NUM_CAP     = 3,
  parameter int LOCK_CYCLES = 64
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wrEn,
  input  logic                            rdEn,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [BYTE_W-1:0]               wdata,
  input  logic [NUM_CAP-1:0]              capStrobe,
  input  logic [CNT_W-1:0]                count,
  input  logic [NUM_CAP-1:0][CNT_W-1:0]   capVal,
  input  logic [BYTE_W-1:0]               holdLo,
  input  logic                            wrapEvt,
  output tmr_ctrl_t                       ctl,
  output logic [BYTE_W-1:0]               rdata,
  output logic                            irq,
  output logic                            lockDone,
  output logic                            ovfFlag,
  output logic [NUM_CAP-1:0]              capFlags
);
  localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);

  logic [LOCK_W-1:0]  lockCnt;
  logic [1:0]         divSel;
  logic               ovfEn;
  logic [NUM_CAP-1:0] capEn;
  logic               wrCtrl, wrOvf, wrCapf;
  logic [BYTE_W-1:0]  ctrlByte, capfByte, rdNext;

  assign wrCtrl   = wrEn && (addr == ADR_CTRL);
  assign wrOvf    = wrEn && (addr == ADR_OVF);
  assign wrCapf   = wrEn && (addr == ADR_CAPF);
  assign lockDone = (lockCnt >= LOCK_W'(LOCK_CYCLES));

  // Cycles since reset, saturating at the window length
  always_ff @(posedge clk) begin
    if (rst)            lockCnt <= '0;
    else if (!lockDone) lockCnt <= lockCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divSel <= 2'b00;
      ovfEn  <= 1'b0;
      capEn  <= '0;
    end else if (wrCtrl) begin
      ovfEn <= wdata[OVF_BIT];
      for (int i = 0; i < NUM_CAP; i++) capEn[i] <= wdata[CAPEN_TOP-i];
      if (!lockDone) divSel <= wdata[1:0];
    end
  end

  // Flags: an event in the same edge beats a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      ovfFlag  <= 1'b0;
      capFlags <= '0;
    end else begin
      ovfFlag <= wrapEvt | (ovfFlag & ~(wrOvf & wdata[OVF_BIT]));
      for (int i = 0; i < NUM_CAP; i++)
        capFlags[i] <= capStrobe[i] | (capFlags[i] & ~(wrCapf & wdata[CAPFLAG_TOP-i]));
    end
  end

  always_comb begin
    ctrlByte          = '0;
    ctrlByte[OVF_BIT] = ovfEn;
    ctrlByte[1:0]     = divSel;
    capfByte          = '0;
    for (int i = 0; i < NUM_CAP; i++) begin
      ctrlByte[CAPEN_TOP-i]   = capEn[i];
      capfByte[CAPFLAG_TOP-i] = capFlags[i];
    end
  end

  always_comb begin
    rdNext = '0;
    if (addr == ADR_CNT_HI)      rdNext = count[CNT_W-1:BYTE_W];
    else if (addr == ADR_CNT_LO) rdNext = holdLo;
    else if (addr == ADR_CTRL)   rdNext = ctrlByte;
    else if (addr == ADR_OVF)    rdNext = {ovfFlag, {(BYTE_W-1){1'b0}}};
    else if (addr == ADR_CAPF)   rdNext = capfByte;
    for (int i = 0; i < NUM_CAP; i++) begin
      if (addr == ADR_CAP_BASE + ADDR_W'(2*i))     rdNext = capVal[i][CNT_W-1:BYTE_W];
      if (addr == ADR_CAP_BASE + ADDR_W'(2*i + 1)) rdNext = capVal[i][BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata <= '0;
    else if (rdEn) rdata <= rdNext;
  end

  always_comb begin
    ctl.divSel = divSel;
    ctl.snapHi = rdEn && (addr == ADR_CNT_HI);
    irq        = (ovfEn & ovfFlag) | (|(capEn & capFlags));
  end
endmodule

// File: rtl/tmr_capture_timer.sv
module tmr_capture_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CAP     = 3,
  parameter int LOCK_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [3:0]         addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  input  logic [NUM_CAP-1:0] capStrobe,
  output logic               irq
);
  tmr_ctrl_t                     ctlW;
  logic [CNT_W-1:0]              countW;
  logic [NUM_CAP-1:0][CNT_W-1:0] capValW;
  logic [BYTE_W-1:0]             holdLoW;
  logic                          tickW, wrapW, lockDoneW, ovfFlagW;
  logic [NUM_CAP-1:0]            capFlagsW;
  logic [1:0]                    divSelW;

  assign divSelW = ctlW.divSel;

  tmr_datapath #(.NUM_CAP(NUM_CAP)) uDp (
    .clk(clk), .rst(rst), .ctl(ctlW), .capStrobe(capStrobe),
    .count(countW), .capVal(capValW), .holdLo(holdLoW),
    .tick(tickW), .wrapEvt(wrapW)
  );

  tmr_ctrl #(.NUM_CAP(NUM_CAP), .LOCK_CYCLES(LOCK_CYCLES)) uCtl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .capStrobe(capStrobe), .count(countW),
    .capVal(capValW), .holdLo(holdLoW), .wrapEvt(wrapW),
    .ctl(ctlW), .rdata(rdata), .irq(irq), .lockDone(lockDoneW),
    .ovfFlag(ovfFlagW), .capFlags(capFlagsW)
  );
endmodule

// File: rtl/tmr_capture_timer_chk.sv
module tmr_capture_timer_chk #(
  parameter int NUM_CAP = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wrEn,
  input logic [3:0]                 addr,
  input logic [NUM_CAP-1:0]         capStrobe,
  input logic                       irq,
  input logic [15:0]                count,
  input logic                       tick,
  input logic                       ovfFlag,
  input logic [NUM_CAP-1:0]         capFlags,
  input logic [1:0]                 divSel,
  input logic                       lockDone,
  input logic [NUM_CAP-1:0][15:0]   capVal
);
  // R1: count advances by one on a tick below the top value
  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    (tick && count != 16'hFFFF) |=> (count == $past(count) + 16'd1));

  // R1: count holds between ticks
  a_r1_count_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

  // R6: rollover raises the overflow flag
  a_r6_wrap_flag: assert property (@(posedge clk) disable iff (rst)
    (tick && count == 16'hFFFF) |=> (ovfFlag && count == 16'h0000));

  // R3: divide select frozen once the window has closed
  a_r3_sel_frozen: assert property (@(posedge clk) disable iff (rst)
    lockDone |=> $stable(divSel));

  // R4: channel 1 takes the pre-edge count
  a_r4_capture: assert property (@(posedge clk) disable iff (rst)
    capStrobe[0] |=> (capVal[0] == $past(count)));

  // R8: overflow flag stays set without a write to its register
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovfFlag && !(wrEn && addr == 4'd9)) |=> ovfFlag);

  // R9: interrupt only with some flag pending
  a_r9_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ovfFlag || capFlags != '0));
endmodule

bind tmr_capture_timer tmr_capture_timer_chk #(.NUM_CAP(NUM_CAP)) uChk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .capStrobe(capStrobe),
  .irq(irq), .count(countW), .tick(tickW), .ovfFlag(ovfFlagW),
  .capFlags(capFlagsW), .divSel(divSelW), .lockDone(lockDoneW),
  .capVal(capValW)
);

// File: tb/tmr_capture_timer_test.sv
module tmr_capture_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CAP    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic [NUM_CAP-1:0] capStrobe = '0;
  logic [7:0] rdata;
  logic irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_capture_timer #(.NUM_CAP(NUM_CAP), .LOCK_CYCLES(64)) uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .capStrobe(capStrobe), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       chkNext = 1'b0;
  logic       pendChk = 1'b0;

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare scoreboarded read data one edge after the strobe
  always @(posedge clk) pendChk <= rdEn & chkNext;
  always @(negedge clk) begin
    if (pendChk) begin
      if (expQ.size() == 0) check(16'(rdata), 16'hDEAD, "R11 unexpected read");
      else check(16'(rdata), 16'(expQ.pop_front()), tagQ.pop_front());
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdExp(input logic [3:0] a, input logic [7:0] e, input string tag);
    expQ.push_back(e); tagQ.push_back(tag);
    rdEn = 1'b1; chkNext = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0; chkNext = 1'b0;
  endtask

  task automatic rdVal(input logic [3:0] a, output logic [7:0] v);
    rdEn = 1'b1; chkNext = 1'b0; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdata;
  endtask

  task automatic rdCap(input int ch, output logic [15:0] v);
    logic [7:0] hi, lo;
    rdVal(4'(2 + 2*ch), hi);
    rdVal(4'(3 + 2*ch), lo);
    v = {hi, lo};
  endtask

  // Capture on channels 1 and 2 exactly 64 edges apart
  task automatic measureDelta(input int expTicks, input string tag);
    logic [15:0] c0, c1;
    capStrobe[0] = 1'b1;
    @(negedge clk);
    capStrobe[0] = 1'b0;
    idle(63);
    capStrobe[1] = 1'b1;
    @(negedge clk);
    capStrobe[1] = 1'b0;
    rdCap(0, c0);
    rdCap(1, c1);
    check(c1 - c0, 16'(expTicks), tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  hi, lo, v;
    logic [15:0] cv;
    int n;

    // Divide by 4 chosen inside the window
    doReset();
    check(16'(irq), 16'h0, "R10 irq after reset");
    rdExp(4'd8, 8'h00, "R10 control after reset");
    rdExp(4'd9, 8'h00, "R10 overflow flag after reset");
    rdExp(4'd10, 8'h00, "R10 capture flags after reset");
    wr(4'd8, 8'h01);
    rdExp(4'd8, 8'h01, "R2 divide field written in window");
    measureDelta(16, "R2 divide by 4");

    // Window closed: divide field ignored, other bits update
    idle(80);
    wr(4'd8, 8'h80);
    rdExp(4'd8, 8'h81, "R3 late write keeps divide, sets enable");
    wr(4'd8, 8'h03);
    rdExp(4'd8, 8'h01, "R3 late write divide unchanged");
    measureDelta(16, "R3 ratio still 4 after late write");

    doReset();
    wr(4'd8, 8'h02);
    measureDelta(8, "R2 divide by 8");

    doReset();
    wr(4'd8, 8'h03);
    measureDelta(4, "R2 divide by 16");

    // Divide by 1 (reset default)
    doReset();
    measureDelta(64, "R10 default divide by 1");
    measureDelta(64, "R1 one step per tick");

    // Snapshot: read upper byte and capture channel 3 in the same edge
    rdEn = 1'b1; addr = 4'd0; capStrobe[2] = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; capStrobe[2] = 1'b0;
    hi = rdata;
    idle(300);
    rdVal(4'd1, lo);
    rdCap(2, cv);
    check({hi, lo}, cv, "R5 held pair matches channel 3 capture R4");

    // Capture flags and write-one-to-clear
    rdExp(4'd10, 8'h07, "R7 all three capture flags");
    wr(4'd10, 8'h00);
    rdExp(4'd10, 8'h07, "R8 zero write leaves flags");
    wr(4'd10, 8'h04);
    rdExp(4'd10, 8'h03, "R8 channel 1 cleared only");
    wr(4'd10, 8'h04);
    rdExp(4'd10, 8'h03, "R8 clear of clear flag no effect");

    // Interrupt gating
    check(16'(irq), 16'h0, "R9 flags without enables");
    wr(4'd8, 8'h20);
    check(16'(irq), 16'h1, "R9 channel 2 enable");
    wr(4'd8, 8'h40);
    check(16'(irq), 16'h0, "R9 channel 1 enable, flag clear");
    wr(4'd8, 8'h10);
    check(16'(irq), 16'h1, "R9 channel 3 enable");
    wr(4'd10, 8'h01);
    check(16'(irq), 16'h0, "R9 R8 channel 3 flag cleared");
    rdExp(4'd10, 8'h02, "R8 channel 2 remains");

    // Set wins over simultaneous clear
    capStrobe[0] = 1'b1;
    wr(4'd10, 8'h04);
    capStrobe[0] = 1'b0;
    rdExp(4'd10, 8'h06, "R8 event beats clear");

    // Overflow at the rollover
    wr(4'd8, 8'h80);
    rdExp(4'd9, 8'h00, "R6 no overflow yet");
    n = 0;
    while (!irq && n < 70000) begin
      @(negedge clk);
      n++;
    end
    check(16'(irq), 16'h1, "R6 overflow interrupt");
    capStrobe[0] = 1'b1;
    @(negedge clk);
    capStrobe[0] = 1'b0;
    rdExp(4'd9, 8'h80, "R6 overflow flag set");
    rdCap(0, cv);
    check(cv, 16'h0000, "R1 wrap to zero with flag");
    wr(4'd9, 8'h7F);
    rdExp(4'd9, 8'h80, "R8 overflow not cleared by zero bit");
    wr(4'd9, 8'h80);
    check(16'(irq), 16'h0, "R8 R9 overflow cleared");
    rdExp(4'd9, 8'h00, "R8 overflow flag cleared");

    // Reset in the middle of a run
    doReset();
    rdExp(4'd8, 8'h00, "R10 control cleared");
    rdExp(4'd10, 8'h00, "R10 capture flags cleared");
    rdExp(4'd9, 8'h00, "R10 overflow cleared");
    rdVal(4'd0, v);
    check(16'(v), 16'h00, "R10 count restarted");

    // Read timing and unmapped addresses
    rdExp(4'd15, 8'h00, "R11 unmapped address");
    wr(4'd8, 8'h50);
    rdVal(4'd8, v);
    idle(5);
    check(16'(rdata), 16'h50, "R11 rdata holds between reads");

    idle(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule